// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Sequencer

This block keeps the buffer descriptors of a simple Ethernet MAC in one shared table and walks a transmit ring and a receive ring through it. Software reaches the table and a ring-split register through a word-addressed register port. Each descriptor has a status/length word and a buffer-address word. A programmable count divides the table: the first `count` entries form the transmit ring and the entries after them form the receive ring. Each ring returns to its own first entry after a descriptor that carries the wrap flag.

On the transmit side the sequencer waits on the current descriptor until software sets its ready flag. It then presents the buffer address, length and pad/CRC requests to a transmit datapath, and holds them until completion is reported. It writes the completion status back, clears ready and moves on. On the receive side every frame the receive datapath reports is stored into the current descriptor if that descriptor is marked empty. Otherwise the frame is dropped and a busy event is raised. Completion, error and busy pulses go to an interrupt block.

Top module: `bdr_ring_seq`

## Requirements
- R1: After reset every table word reads 0, the ring-split count reads NUM_DESC/2 (8 by default), `tx_req` is low and no event pulses.
- R2: The ring-split count sits at word address 0x008 (byte 0x20). A written value above min(NUM_DESC,128) is stored as that limit. A write sends the transmit pointer to entry 0, sends the receive pointer to entry `count`, and drops any transmit request in progress.
- R3: Descriptor i occupies word addresses 0x100+2i (status/length) and 0x101+2i (buffer address), i.e. byte 0x400 onward. Both words can be written and read back.
- R4: The transmit side stays on its current descriptor until that descriptor's bit 15 (ready) is set. One clock after it sees ready, it raises `tx_req` with the address word, length from bits 31:16, `tx_pad` from bit 12 and `tx_crc` from bit 11. These outputs hold steady until `tx_done`.
- R5: On `tx_done` the status word becomes {bits 31:16 unchanged, bit 15 cleared, bits 14:9 unchanged, bits 8:0 = `tx_stat`}. The `tx_stat` layout is: bit 0 carrier lost, bit 1 deferred, bit 2 late collision, bit 3 retry limit, bits 7:4 retry count, bit 8 underrun.
- R6: After completion the transmit pointer moves to the next entry. It goes to entry 0 instead when bit 13 (wrap) was set or the entry was the last in the table.
- R7: `tx_evt` pulses for one cycle, one clock after `tx_done`, only when bit 14 of the descriptor is set. `tx_err` pulses in the same cycle when `tx_stat` bit 0, 2, 3 or 8 is set.
- R8: A receive frame (`rx_valid`) arriving while the current receive descriptor has bit 15 (empty) set is stored in that descriptor. The status word becomes {`rx_len`, bit 15 cleared, bits 14:9 unchanged, bits 8:0 = `rx_stat`}, and the address word is left as it was. `rx_evt` pulses one clock later if bit 14 is set.
- R9: After a stored frame the receive pointer moves to the next entry. It goes to entry `count` instead when bit 13 was set or the entry was the last in the table.
- R10: A frame arriving while the current receive descriptor is not empty, or while the receive ring holds no entries, leaves the table and the pointer unchanged. It pulses `rx_busy` one clock later and raises no `rx_evt`.
- R11: `rx_err` pulses with a stored frame when any `rx_stat` bit 0, 1, 2, 3, 5, 6 or 7 is set. Bit 4 (dribble nibble) and bit 8 (control frame) are not errors.
- R12: Software writes to a descriptor that hardware owns are accepted. A write-back never alters the address word. When software writes a status word in the same cycle that hardware writes it back, the hardware value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| tx_req | output | 1 | Transmit request to datapath |
| tx_buf_addr | output | 32 | Buffer address of the frame to send |
| tx_len | output | 16 | Frame length |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append CRC |
| tx_done | input | 1 | Transmit completion strobe |
| tx_stat | input | 9 | Transmit completion status |
| rx_valid | input | 1 | Received frame strobe |
| rx_len | input | 16 | Received length including CRC |
| rx_stat | input | 9 | Receive status flags |
| tx_evt | output | 1 | Transmit completion event |
| tx_err | output | 1 | Transmit error event |
| rx_evt | output | 1 | Receive completion event |
| rx_err | output | 1 | Receive error event |
| rx_busy | output | 1 | Frame dropped, no empty descriptor |

## Verification
Every event output is registered, so it is due one clock after the strobe that caused it. `tx_req` rises one clock after the edge that stores the ready flag, and table write-backs become readable right after the strobe's edge. The bench drives inputs on falling edges. A behavioural model advances on each rising edge, and on each falling edge all outputs are compared against that model, so every result is checked in exactly the cycle it is due. Directed readbacks of the table sample `reg_rdata` a short delay after the address is set.

// File: rtl/bdr_pkg.sv
`timescale 1ns/1ps
// Shared field positions, error masks and the write-back word builder.
// Assumes 32-bit descriptor words with the length in the upper half.
package bdr_pkg;
    localparam int F_OWN  = 15;  // ready (tx) / empty (rx)
    localparam int F_IRQ  = 14;
    localparam int F_WRAP = 13;
    localparam int F_PAD  = 12;
    localparam int F_CRC  = 11;

    localparam logic [8:0] TX_ERR_MASK = 9'h10D;  // carrier, late coll, retry limit, underrun
    localparam logic [8:0] RX_ERR_MASK = 9'h0EF;  // all of 7:0 except dribble

    // Builds the status word written on completion: owner flag cleared.
    function automatic logic [31:0] wb_word(input logic [15:0] len,
                                            input logic [5:0] ctl,
                                            input logic [8:0] st);
        return {len, 1'b0, ctl, st};
    endfunction
endpackage

// File: rtl/bdr_table.sv
`timescale 1ns/1ps
// Descriptor storage: NUM_DESC entries of status and address words.
// Assumes the two hardware write-back ports never target the same entry
// (rings are disjoint); hardware write-back beats a software status write.
module bdr_table #(
    parameter int NUM_DESC = 16,
    localparam int IDX_W = $clog2(NUM_DESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic             sw_word,
    input  logic [31:0]      sw_wdata,
    output logic [31:0]      sw_rdata,
    input  logic [IDX_W-1:0] tx_idx,
    output logic [31:9]      tx_hi,
    output logic [31:0]      tx_ad,
    input  logic             tx_wb_en,
    input  logic [31:0]      tx_wb,
    input  logic [IDX_W-1:0] rx_idx,
    output logic [15:9]      rx_ctl,
    input  logic             rx_wb_en,
    input  logic [31:0]      rx_wb
);
    logic [31:0] st_q [NUM_DESC];
    logic [31:0] ad_q [NUM_DESC];

    // Storage update: hardware write-back first, software otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DESC; i++) begin
                st_q[i] <= '0;
                ad_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_DESC; i++) begin
                if (tx_wb_en && tx_idx == IDX_W'(i))
                    st_q[i] <= tx_wb;
                else if (rx_wb_en && rx_idx == IDX_W'(i))
                    st_q[i] <= rx_wb;
                else if (sw_we && !sw_word && sw_idx == IDX_W'(i))
                    st_q[i] <= sw_wdata;
                if (sw_we && sw_word && sw_idx == IDX_W'(i))
                    ad_q[i] <= sw_wdata;
            end
        end
    end

    // Read ports for software and both walkers.
    always_comb begin
        sw_rdata = sw_word ? ad_q[sw_idx] : st_q[sw_idx];
        tx_hi    = st_q[tx_idx][31:9];
        tx_ad    = ad_q[tx_idx];
        rx_ctl   = st_q[rx_idx][15:9];
    end
endmodule

// File: rtl/bdr_tx_walk.sv
`timescale 1ns/1ps
// Transmit ring walker: waits for ready on the current entry, holds the
// request to the datapath until done, writes status back and advances.
// Assumes the datapath raises tx_done only while tx_req is high.
module bdr_tx_walk
    import bdr_pkg::*;
#(
    parameter int NUM_DESC = 16,
    parameter int CNT_W = 5,
    localparam int IDX_W = $clog2(NUM_DESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [31:9]      cur_hi,
    input  logic [31:0]      cur_ad,
    output logic [IDX_W-1:0] ptr,
    input  logic             tx_done,
    input  logic [8:0]       tx_stat,
    output logic             wb_en,
    output logic [31:0]      wb_data,
    output logic             tx_req,
    output logic [31:0]      tx_buf_addr,
    output logic [15:0]      tx_len,
    output logic             tx_pad,
    output logic             tx_crc,
    output logic             tx_evt,
    output logic             tx_err
);
    logic             busy_q, evt_q, err_q, pad_q, crc_q;
    logic [31:0]      addr_q;
    logic [15:0]      len_q;
    logic [IDX_W-1:0] ptr_q, ptr_nx;
    logic             finish;

    // Completion write-back and next-entry selection.
    always_comb begin
        finish  = busy_q && tx_done;
        wb_en   = finish;
        wb_data = wb_word(cur_hi[31:16], cur_hi[14:9], tx_stat);
        ptr_nx  = (cur_hi[F_WRAP] || ptr_q == IDX_W'(NUM_DESC - 1)) ? '0 : ptr_q + 1'b1;
    end

    // Ring state: pick up ready entries, complete, advance or restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0; ptr_q <= '0; evt_q <= 1'b0; err_q <= 1'b0;
            addr_q <= '0; len_q <= '0; pad_q <= 1'b0; crc_q <= 1'b0;
        end else begin
            evt_q <= finish && cur_hi[F_IRQ];
            err_q <= finish && |(tx_stat & TX_ERR_MASK);
            if (restart) begin
                busy_q <= 1'b0;
                ptr_q  <= '0;
            end else if (busy_q) begin
                if (tx_done) begin
                    busy_q <= 1'b0;
                    ptr_q  <= ptr_nx;
                end
            end else if (tx_count != '0 && cur_hi[F_OWN]) begin
                busy_q <= 1'b1;
                addr_q <= cur_ad;
                len_q  <= cur_hi[31:16];
                pad_q  <= cur_hi[F_PAD];
                crc_q  <= cur_hi[F_CRC];
            end
        end
    end

    assign ptr         = ptr_q;
    assign tx_req      = busy_q;
    assign tx_buf_addr = addr_q;
    assign tx_len      = len_q;
    assign tx_pad      = pad_q;
    assign tx_crc      = crc_q;
    assign tx_evt      = evt_q;
    assign tx_err      = err_q;

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done && !restart) |=> (tx_req && $stable(tx_buf_addr) && $stable(tx_len)));
    p_evt_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_evt || tx_err) |-> $past(tx_done && tx_req));
endmodule

// File: rtl/bdr_rx_walk.sv
`timescale 1ns/1ps
// Receive ring walker: stores each reported frame into the current empty
// entry or drops it with a busy pulse. Assumes rx_valid is a one-cycle strobe.
module bdr_rx_walk
    import bdr_pkg::*;
#(
    parameter int NUM_DESC = 16,
    parameter int CNT_W = 5,
    parameter int RST_BASE = 8,
    localparam int IDX_W = $clog2(NUM_DESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] new_base,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [15:9]      cur_ctl,
    output logic [IDX_W-1:0] ptr,
    input  logic             rx_valid,
    input  logic [15:0]      rx_len,
    input  logic [8:0]       rx_stat,
    output logic             wb_en,
    output logic [31:0]      wb_data,
    output logic             rx_evt,
    output logic             rx_err,
    output logic             rx_busy
);
    logic [IDX_W-1:0] ptr_q, ptr_nx;
    logic             take, evt_q, err_q, busy_q;

    // Accept decision, write-back word and next entry.
    always_comb begin
        take    = rx_valid && (32'(tx_count) < NUM_DESC) && cur_ctl[F_OWN];
        wb_en   = take;
        wb_data = wb_word(rx_len, cur_ctl[14:9], rx_stat);
        ptr_nx  = (cur_ctl[F_WRAP] || ptr_q == IDX_W'(NUM_DESC - 1)) ? IDX_W'(tx_count)
                                                                      : ptr_q + 1'b1;
    end

    // Pointer and event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= IDX_W'(RST_BASE); evt_q <= 1'b0; err_q <= 1'b0; busy_q <= 1'b0;
        end else begin
            evt_q  <= take && cur_ctl[F_IRQ];
            err_q  <= take && |(rx_stat & RX_ERR_MASK);
            busy_q <= rx_valid && !take;
            if (restart)
                ptr_q <= IDX_W'(new_base);
            else if (take)
                ptr_q <= ptr_nx;
        end
    end

    assign ptr     = ptr_q;
    assign rx_evt  = evt_q;
    assign rx_err  = err_q;
    assign rx_busy = busy_q;

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_evt, rx_busy}) && $onehot0({rx_err, rx_busy}));
    p_busy_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |-> $past(rx_valid));
endmodule

// File: rtl/bdr_ring_seq.sv
`timescale 1ns/1ps
// Top: register decode, ring-split count and the two ring walkers around
// the shared descriptor table. Assumes NUM_DESC is a power of two.
module bdr_ring_seq #(
    parameter int NUM_DESC = 16,
    parameter int AW = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        tx_req,
    output logic [31:0] tx_buf_addr,
    output logic [15:0] tx_len,
    output logic        tx_pad,
    output logic        tx_crc,
    input  logic        tx_done,
    input  logic [8:0]  tx_stat,
    input  logic        rx_valid,
    input  logic [15:0] rx_len,
    input  logic [8:0]  rx_stat,
    output logic        tx_evt,
    output logic        tx_err,
    output logic        rx_evt,
    output logic        rx_err,
    output logic        rx_busy
);
    localparam int TXMAX = (NUM_DESC < 128) ? NUM_DESC : 128;
    localparam int IDX_W = $clog2(NUM_DESC);
    localparam int CNT_W = $clog2(TXMAX + 1);
    localparam logic [AW-1:0] CNT_ADDR = AW'(8);
    localparam logic [AW-1:0] TBL_BASE = AW'(256);
    localparam logic [AW:0]   TBL_END  = (AW + 1)'(256 + 2 * NUM_DESC);

    logic [CNT_W-1:0] cnt_q, cnt_wr;
    logic             is_cnt, is_tbl, restart;
    logic [AW-1:0]    tbl_off;
    logic [IDX_W-1:0] sw_idx, tx_ptr, rx_ptr;
    logic [31:0]      tbl_rdata, tx_ad, tx_wb, rx_wb;
    logic [31:9]      tx_hi;
    logic [15:9]      rx_ctl;
    logic             tx_wb_en, rx_wb_en;

    // Address decode and clamped count value.
    always_comb begin
        is_cnt  = reg_addr == CNT_ADDR;
        is_tbl  = reg_addr >= TBL_BASE && {1'b0, reg_addr} < TBL_END;
        tbl_off = reg_addr - TBL_BASE;
        sw_idx  = IDX_W'(tbl_off >> 1);
        restart = reg_we && is_cnt;
        cnt_wr  = (reg_wdata > 32'(TXMAX)) ? CNT_W'(TXMAX) : CNT_W'(reg_wdata);
    end

    // Ring-split count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_W'(TXMAX / 2);
        else if (restart)
            cnt_q <= cnt_wr;
    end

    // Read-data multiplexer.
    always_comb begin
        if (is_cnt)      reg_rdata = 32'(cnt_q);
        else if (is_tbl) reg_rdata = tbl_rdata;
        else             reg_rdata = '0;
    end

    bdr_table #(.NUM_DESC(NUM_DESC)) u_table (
        .clk(clk), .rst_n(rst_n),
        .sw_we(reg_we && is_tbl), .sw_idx(sw_idx), .sw_word(tbl_off[0]),
        .sw_wdata(reg_wdata), .sw_rdata(tbl_rdata),
        .tx_idx(tx_ptr), .tx_hi(tx_hi), .tx_ad(tx_ad), .tx_wb_en(tx_wb_en), .tx_wb(tx_wb),
        .rx_idx(rx_ptr), .rx_ctl(rx_ctl), .rx_wb_en(rx_wb_en), .rx_wb(rx_wb)
    );

    bdr_tx_walk #(.NUM_DESC(NUM_DESC), .CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tx_count(cnt_q),
        .cur_hi(tx_hi), .cur_ad(tx_ad), .ptr(tx_ptr),
        .tx_done(tx_done), .tx_stat(tx_stat), .wb_en(tx_wb_en), .wb_data(tx_wb),
        .tx_req(tx_req), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len),
        .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_evt(tx_evt), .tx_err(tx_err)
    );

    bdr_rx_walk #(.NUM_DESC(NUM_DESC), .CNT_W(CNT_W), .RST_BASE(TXMAX / 2)) u_rx (
        .clk(clk), .rst_n(rst_n), .restart(restart), .new_base(cnt_wr), .tx_count(cnt_q),
        .cur_ctl(rx_ctl), .ptr(rx_ptr),
        .rx_valid(rx_valid), .rx_len(rx_len), .rx_stat(rx_stat),
        .wb_en(rx_wb_en), .wb_data(rx_wb),
        .rx_evt(rx_evt), .rx_err(rx_err), .rx_busy(rx_busy)
    );

    p_cnt_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) <= TXMAX);
    p_rx_in_ring_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_wb_en && !restart) |-> (32'(rx_ptr) >= 32'(cnt_q) || 32'(cnt_q) >= NUM_DESC));
endmodule

// File: tb/bdr_ring_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped on each rising edge and
// compared with every output on each falling edge, plus directed readbacks.
module bdr_ring_seq_tb_top;
    localparam int ND = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_req, tx_pad, tx_crc, tx_evt, tx_err, rx_evt, rx_err, rx_busy;
    logic [31:0] tx_buf_addr;
    logic [15:0] tx_len;
    logic        tx_done = 1'b0;
    logic [8:0]  tx_stat = '0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_len = '0;
    logic [8:0]  rx_stat = '0;

    int total = 0;
    int bad = 0;
    bit fin = 1'b0;

    always #5 clk = ~clk;

    bdr_ring_seq #(.NUM_DESC(ND)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_req(tx_req), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len),
        .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done), .tx_stat(tx_stat),
        .rx_valid(rx_valid), .rx_len(rx_len), .rx_stat(rx_stat),
        .tx_evt(tx_evt), .tx_err(tx_err), .rx_evt(rx_evt), .rx_err(rx_err), .rx_busy(rx_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0] m_st [ND];
    logic [31:0] m_ad [ND];
    int  m_cnt, m_tp, m_rp;
    bit  m_busy;
    logic [31:0] e_addr;
    logic [15:0] e_len;
    bit  e_pad, e_crc, e_txevt, e_txerr, e_rxevt, e_rxerr, e_rxbusy;

    always @(posedge clk) begin
        int hw_tx, hw_rx, c, idx;
        logic [31:0] s;
        if (!rst_n) begin
            for (int i = 0; i < ND; i++) begin m_st[i] = 0; m_ad[i] = 0; end
            m_cnt = ND / 2; m_tp = 0; m_rp = ND / 2; m_busy = 0;
            e_txevt = 0; e_txerr = 0; e_rxevt = 0; e_rxerr = 0; e_rxbusy = 0;
        end else begin
            hw_tx = -1; hw_rx = -1;
            e_txevt = 0; e_txerr = 0; e_rxevt = 0; e_rxerr = 0; e_rxbusy = 0;
            if (m_busy) begin
                if (tx_done) begin
                    s = m_st[m_tp];
                    m_st[m_tp] = {s[31:16], 1'b0, s[14:9], tx_stat};
                    e_txevt = s[14];
                    e_txerr = tx_stat[0] | tx_stat[2] | tx_stat[3] | tx_stat[8];
                    hw_tx = m_tp;
                    m_tp = (s[13] || m_tp == ND - 1) ? 0 : m_tp + 1;
                    m_busy = 0;
                end
            end else if (m_cnt != 0 && m_st[m_tp][15]) begin
                m_busy = 1;
                e_addr = m_ad[m_tp];
                e_len  = m_st[m_tp][31:16];
                e_pad  = m_st[m_tp][12];
                e_crc  = m_st[m_tp][11];
            end
            if (rx_valid) begin
                if (m_cnt < ND && m_st[m_rp][15]) begin
                    s = m_st[m_rp];
                    m_st[m_rp] = {rx_len, 1'b0, s[14:9], rx_stat};
                    e_rxevt = s[14];
                    e_rxerr = (rx_stat & 9'h0EF) != 0;
                    hw_rx = m_rp;
                    m_rp = (s[13] || m_rp == ND - 1) ? m_cnt : m_rp + 1;
                end else begin
                    e_rxbusy = 1;
                end
            end
            if (reg_we) begin
                if (reg_addr == 10'h008) begin
                    c = (reg_wdata > ND) ? ND : int'(reg_wdata);
                    m_cnt = c; m_tp = 0; m_rp = c % ND; m_busy = 0;
                end else if (reg_addr >= 10'h100 && reg_addr < 10'h100 + 2 * ND) begin
                    idx = (int'(reg_addr) - 256) / 2;
                    if (reg_addr[0]) m_ad[idx] = reg_wdata;
                    else if (idx != hw_tx && idx != hw_rx) m_st[idx] = reg_wdata;
                end
            end
        end
    end

    // Per-cycle comparison on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk("R4 tx_req", 32'(tx_req), 32'(m_busy));
            if (m_busy) begin
                chk("R4 tx_buf_addr", tx_buf_addr, e_addr);
                chk("R4 tx_len", 32'(tx_len), 32'(e_len));
                chk("R4 tx_pad/crc", {30'b0, tx_pad, tx_crc}, {30'b0, e_pad, e_crc});
            end
            chk("R7 tx_evt", 32'(tx_evt), 32'(e_txevt));
            chk("R7 tx_err", 32'(tx_err), 32'(e_txerr));
            chk("R8 rx_evt", 32'(rx_evt), 32'(e_rxevt));
            chk("R11 rx_err", 32'(rx_err), 32'(e_rxerr));
            chk("R10 rx_busy", 32'(rx_busy), 32'(e_rxbusy));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic txd(input logic [8:0] st);
        tx_done = 1'b1; tx_stat = st;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic rxf(input logic [15:0] l, input logic [8:0] st);
        rx_valid = 1'b1; rx_len = l; rx_stat = st;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(10'h008, 32'd8, "R1 count reset");
        rd(10'h100, 32'h0, "R1 status word reset");
        rd(10'h11F, 32'h0, "R1 address word reset");
        chk("R1 tx_req low", 32'(tx_req), 32'h0);
        // R2 clamp and program
        wr(10'h008, 32'd200);
        rd(10'h008, 32'd16, "R2 count clamp");
        wr(10'h008, 32'd4);
        rd(10'h008, 32'd4, "R2 count value");
        // R3 table access
        wr(10'h101, 32'h1000_0000);
        wr(10'h103, 32'h1000_0800);
        wr(10'h100, 32'h003C_5800);
        rd(10'h103, 32'h1000_0800, "R3 address word");
        rd(10'h100, 32'h003C_5800, "R3 status word");
        repeat (3) @(negedge clk);
        chk("R4 no request without ready", 32'(tx_req), 32'h0);
        // R4 pick-up one clock after ready is stored
        wr(10'h100, 32'h003C_D800);
        chk("R4 not yet", 32'(tx_req), 32'h0);
        @(negedge clk);
        chk("R4 request", 32'(tx_req), 32'h1);
        chk("R4 address", tx_buf_addr, 32'h1000_0000);
        chk("R4 length", 32'(tx_len), 32'd60);
        // R12 software writes owned descriptor's address
        wr(10'h101, 32'h3000_0000);
        chk("R4 address held", tx_buf_addr, 32'h1000_0000);
        @(negedge clk);
        txd(9'h104);
        chk("R7 tx_evt with irq", 32'(tx_evt), 32'h1);
        chk("R7 tx_err late coll/underrun", 32'(tx_err), 32'h1);
        rd(10'h100, 32'h003C_5904, "R5 write-back");
        rd(10'h101, 32'h3000_0000, "R12 address kept");
        // R6 advance, then wrap
        wr(10'h102, 32'h0040_A000);
        @(negedge clk);
        chk("R6 next entry", tx_buf_addr, 32'h1000_0800);
        txd(9'h020);
        chk("R7 no irq no evt", 32'(tx_evt), 32'h0);
        chk("R7 retry count not error", 32'(tx_err), 32'h0);
        rd(10'h102, 32'h0040_2020, "R5 write-back wrap entry");
        wr(10'h100, 32'h0020_8000);
        @(negedge clk);
        chk("R6 wrapped to 0", tx_buf_addr, 32'h3000_0000);
        chk("R6 wrapped length", 32'(tx_len), 32'd32);
        txd(9'h000);
        // Receive ring begins at entry 4
        wr(10'h109, 32'h2000_0000);
        wr(10'h108, 32'h0000_C000);
        wr(10'h10A, 32'h0000_A000);
        rxf(16'd64, 9'h000);
        chk("R8 rx_evt", 32'(rx_evt), 32'h1);
        rd(10'h108, 32'h0040_4000, "R8 status stored");
        rd(10'h109, 32'h2000_0000, "R8 address kept");
        rxf(16'd100, 9'h010);
        chk("R11 dribble not error", 32'(rx_err), 32'h0);
        chk("R8 no irq no evt", 32'(rx_evt), 32'h0);
        rd(10'h10A, 32'h0064_2010, "R9 second entry used");
        rxf(16'd70, 9'h000);
        chk("R10 busy", 32'(rx_busy), 32'h1);
        rd(10'h108, 32'h0040_4000, "R10 descriptor untouched");
        wr(10'h108, 32'h0000_C000);
        rxf(16'd72, 9'h002);
        chk("R11 crc error", 32'(rx_err), 32'h1);
        rd(10'h108, 32'h0048_4002, "R9 wrap to ring start");
        // R12 simultaneous write: hardware wins
        wr(10'h10A, 32'h0000_A000);
        rx_valid = 1'b1; rx_len = 16'd80; rx_stat = 9'h000;
        reg_we = 1'b1; reg_addr = 10'h10A; reg_wdata = 32'hAAAA_8000;
        @(negedge clk);
        rx_valid = 1'b0; reg_we = 1'b0;
        rd(10'h10A, 32'h0050_2000, "R12 hardware write-back kept");
        // R2 count write moves receive start
        wr(10'h008, 32'd2);
        wr(10'h105, 32'h4000_0000);
        wr(10'h104, 32'h0000_C000);
        rxf(16'd90, 9'h000);
        chk("R2 rx pointer reset", 32'(rx_evt), 32'h1);
        rd(10'h104, 32'h005A_4000, "R2 entry at new start");
        repeat (2) @(negedge clk);
        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule